// File: doc/BRIEF.md
# Sticky Interrupt Status Register with Zero-Write Clearing

This block holds the interrupt status of a USB host/function controller. Ten per-pipe buffer-ready events and two global events are captured into sticky status bits. The global events are the ACK of a host-issued setup transaction and a change of bus state. Each event arrives as a one-cycle pulse. Software reads the bits through a small register port. It clears a bit by writing 0 to that bit position. Any bit written with 1 keeps its value, so one write can clear a chosen subset of bits without a read-modify-write race.

A single interrupt line is formed from every status bit that has its enable input set, and it is registered. A clock-supply flag models the controller's gated clock. While the flag is low, only the bus-change bit stays alive. It can still be set, cleared and raise the interrupt. Every other bit ignores both its events and clearing writes until the flag returns.

Top module: `wzc_irq_status`

## Requirements
- R1: A pulse on `pipe_rdy_evt[n]` (n = 0..9) sets bit n of the pipe status view (`rd_sel`=1). The bit is readable on `rd_data` after the next rising clock edge.
- R2: A write sets bits to 0 only where `wr_data` holds 0. Positions written with 1 keep their value. `wr_sel`=1 selects the pipe view and `wr_sel`=0 selects the global view.
- R3: Unused positions always read 0 and ignore writes. These are bits 15..10 of the pipe view and every global-view bit except 14 and 4.
- R4: A pulse on `setup_ack_evt` sets bit 4 of the global view (`rd_sel`=0).
- R5: A pulse on `bus_chg_evt` sets bit 14 of the global view whatever the value of `clk_supply_on`. A zero-write clears that bit in either state of the flag.
- R6: While `clk_supply_on` is 0, pipe events and the setup-ACK event are discarded and leave their bits unchanged.
- R7: While `clk_supply_on` is 0, zero-writes to any bit other than bit 14 of the global view have no effect.
- R8: If an event and a zero-write hit the same bit in the same cycle, the bit ends up 1.
- R9: `irq_out` is 1 exactly when, at the previous clock edge, some status bit and its enable input were both 1.
- R10: A synchronous reset clears every status bit and drives `irq_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_supply_on | input | 1 | Clock-supply flag; 0 freezes every bit except bus-change |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 pipe view, 0 global view |
| wr_data | input | 16 | Write data; a 0 clears the bit at that position |
| rd_sel | input | 1 | Read view: 1 pipe view, 0 global view |
| rd_data | output | 16 | Combinational read of the selected view |
| pipe_rdy_evt | input | 10 | Per-pipe buffer-ready pulses |
| setup_ack_evt | input | 1 | Setup-transaction ACK pulse |
| bus_chg_evt | input | 1 | Bus-state change pulse |
| pipe_en | input | 10 | Per-pipe interrupt enables |
| setup_ack_en | input | 1 | Setup-ACK interrupt enable |
| bus_chg_en | input | 1 | Bus-change interrupt enable |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The main function is driven with single-pipe, multi-pipe and all-pipe event patterns. These show that each pipe lands on its own bit. Clearing writes use an all-ones-but-one mask, an alternating mask, an all-zero mask and an all-ones mask. This separates real zero-clearing from a plain store or a toggle. The same clearing and event pulses are repeated with the clock-supply flag low. This tells apart the bus-change bit, which stays live, from the frozen bits. Event-and-clear collisions and enable-masked status show event priority and enable gating of the interrupt.

// File: rtl/wzc_irq_pkg.sv
package wzc_irq_pkg;

    localparam int REG_W        = 16;
    localparam int PIPE_CNT     = 10;
    localparam int GLOB_CNT     = 2;
    // bit positions in the global view
    localparam int SETUP_ACK_POS = 4;
    localparam int BUS_CHG_POS   = 14;
    // index of each global event inside the compact global bank
    localparam int GIDX_ACK     = 0;
    localparam int GIDX_BUS     = 1;
    localparam int IRQ_SRC_CNT  = PIPE_CNT + GLOB_CNT;

    typedef enum logic {
        VIEW_GLOBAL = 1'b0,
        VIEW_PIPE   = 1'b1
    } view_e;

    typedef struct packed {
        logic             we;
        view_e            view;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic bus_chg;
        logic setup_ack;
    } glob_bits_t;

    // place the compact global bank into its register-view layout
    function automatic logic [REG_W-1:0] glob_view(input glob_bits_t g);
        logic [REG_W-1:0] v;
        v = '0;
        v[SETUP_ACK_POS] = g.setup_ack;
        v[BUS_CHG_POS]   = g.bus_chg;
        return v;
    endfunction

    // pull the global bank's clearing bits out of the view layout
    function automatic glob_bits_t glob_pick(input logic [REG_W-1:0] v);
        glob_bits_t g;
        g.setup_ack = v[SETUP_ACK_POS];
        g.bus_chg   = v[BUS_CHG_POS];
        return g;
    endfunction

endpackage

// File: rtl/wzc_status_bank.sv
module wzc_status_bank #(
    parameter int          WIDTH     = 10,
    parameter logic [31:0] LIVE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_supply_on,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    output logic [WIDTH-1:0] stat_q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic allow;
        logic set_b;
        logic clr_b;

        if (LIVE_MASK[i]) begin : g_live
            assign allow = 1'b1;
        end else begin : g_gated
            assign allow = clk_supply_on;
        end

        assign set_b = allow & evt[i];
        assign clr_b = allow & clr_we & ~clr_data[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
            end else if (set_b) begin
                stat_q[i] <= 1'b1;
            end else if (clr_b) begin
                stat_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wzc_irq_merge.sv
module wzc_irq_merge #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] stat,
    input  logic [WIDTH-1:0] en,
    output logic             irq_q
);

    logic pend;
    assign pend = |(stat & en);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend;
    end

endmodule

// File: rtl/wzc_irq_status.sv
module wzc_irq_status
    import wzc_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_supply_on,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                rd_sel,
    output logic [REG_W-1:0]    rd_data,
    input  logic [PIPE_CNT-1:0] pipe_rdy_evt,
    input  logic                setup_ack_evt,
    input  logic                bus_chg_evt,
    input  logic [PIPE_CNT-1:0] pipe_en,
    input  logic                setup_ack_en,
    input  logic                bus_chg_en,
    output logic                irq_out
);

    localparam logic [31:0] GLOB_LIVE = 32'(1) << GIDX_BUS;

    reg_wr_t                wr;
    logic [PIPE_CNT-1:0]    pipe_q;
    logic [GLOB_CNT-1:0]    glob_q;
    glob_bits_t             glob_evt;
    glob_bits_t             glob_clr;
    glob_bits_t             glob_en;
    logic                   unused_wbits;

    assign wr.we   = wr_en;
    assign wr.view = view_e'(wr_sel);
    assign wr.data = wr_data;

    assign glob_evt.setup_ack = setup_ack_evt;
    assign glob_evt.bus_chg   = bus_chg_evt;
    assign glob_clr           = glob_pick(wr.data);
    assign glob_en.setup_ack  = setup_ack_en;
    assign glob_en.bus_chg    = bus_chg_en;

    // reserved positions of the write data carry no state
    assign unused_wbits = ^wr.data[REG_W-1:PIPE_CNT];

    wzc_status_bank #(
        .WIDTH    (PIPE_CNT),
        .LIVE_MASK('0)
    ) pipe_bank_i (
        .clk          (clk),
        .rst          (rst),
        .clk_supply_on(clk_supply_on),
        .evt          (pipe_rdy_evt),
        .clr_we       (wr.we && wr.view == VIEW_PIPE),
        .clr_data     (wr.data[PIPE_CNT-1:0]),
        .stat_q       (pipe_q)
    );

    wzc_status_bank #(
        .WIDTH    (GLOB_CNT),
        .LIVE_MASK(GLOB_LIVE)
    ) glob_bank_i (
        .clk          (clk),
        .rst          (rst),
        .clk_supply_on(clk_supply_on),
        .evt          (glob_evt),
        .clr_we       (wr.we && wr.view == VIEW_GLOBAL),
        .clr_data     (glob_clr),
        .stat_q       (glob_q)
    );

    wzc_irq_merge #(
        .WIDTH(IRQ_SRC_CNT)
    ) merge_i (
        .clk  (clk),
        .rst  (rst),
        .stat ({glob_q, pipe_q}),
        .en   ({glob_en, pipe_en}),
        .irq_q(irq_out)
    );

    always_comb begin
        if (view_e'(rd_sel) == VIEW_PIPE) begin
            rd_data = {{(REG_W-PIPE_CNT){1'b0}}, pipe_q};
        end else begin
            rd_data = glob_view(glob_bits_t'(glob_q));
        end
    end

endmodule

// File: rtl/wzc_irq_status_chk.sv
module wzc_irq_status_chk
    import wzc_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                clk_supply_on,
    input logic                rd_sel,
    input logic [REG_W-1:0]    rd_data,
    input logic [PIPE_CNT-1:0] pipe_rdy_evt,
    input logic                bus_chg_evt,
    input logic [PIPE_CNT-1:0] pipe_en,
    input logic                setup_ack_en,
    input logic                bus_chg_en,
    input logic                irq_out,
    input logic [PIPE_CNT-1:0] pipe_q,
    input logic [GLOB_CNT-1:0] glob_q
);

    // pipe bits frozen while the clock supply is off (R6, R7)
    assert_pipe_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        !clk_supply_on |=> pipe_q == $past(pipe_q));

    // a live bus-change event always lands (R5)
    assert_bus_capture_R5: assert property (@(posedge clk) disable iff (rst)
        bus_chg_evt |=> glob_q[GIDX_BUS]);

    // pipe events win over a simultaneous clear (R8)
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_supply_on && |pipe_rdy_evt) |=>
            ((pipe_q & $past(pipe_rdy_evt)) == $past(pipe_rdy_evt)));

    // interrupt follows masked status one edge later (R9)
    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out == $past(|({glob_q, pipe_q} &
                                    {bus_chg_en, setup_ack_en, pipe_en})));

    // reserved pipe-view positions read zero (R3)
    assert_pipe_rsvd_R3: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> rd_data[REG_W-1:PIPE_CNT] == '0);

    // reserved global-view positions read zero (R3)
    assert_glob_rsvd_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_sel |-> $countones(rd_data) <= 2 && rd_data[SETUP_ACK_POS-1:0] == '0);

endmodule

bind wzc_irq_status wzc_irq_status_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .clk_supply_on(clk_supply_on),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .pipe_rdy_evt (pipe_rdy_evt),
    .bus_chg_evt  (bus_chg_evt),
    .pipe_en      (pipe_en),
    .setup_ack_en (setup_ack_en),
    .bus_chg_en   (bus_chg_en),
    .irq_out      (irq_out),
    .pipe_q       (pipe_q),
    .glob_q       (glob_q)
);

// File: tb/wzc_irq_status_tb.sv
module wzc_irq_status_tb_top;

    typedef struct packed {
        logic        clk_on;
        logic        we;
        logic        sel;
        logic [15:0] wd;
        logic [9:0]  pevt;
        logic        bus;
        logic        ack;
        logic [9:0]  pen;
        logic        busen;
        logic        acken;
        logic [15:0] xp;
        logic [15:0] xg;
        logic        xirq;
    } vec_t;

    localparam int NV = 14;
    // global view: bit 14 bus change, bit 4 setup ACK; pipe view: bit n pipe n
    localparam vec_t VECS [NV] = '{
        // R1 pipes 0 and 2 set, pipe 0 enabled
        '{1'b1,1'b0,1'b0,16'h0000,10'h005,1'b0,1'b0,10'h001,1'b0,1'b0,16'h0005,16'h0000,1'b1},
        // R2 clear bit 0 only, bit 2 kept
        '{1'b1,1'b1,1'b1,16'hFFFE,10'h000,1'b0,1'b0,10'h001,1'b0,1'b0,16'h0004,16'h0000,1'b0},
        // R4 setup ACK at bit 4, pipe 9
        '{1'b1,1'b0,1'b0,16'h0000,10'h200,1'b0,1'b1,10'h000,1'b0,1'b1,16'h0204,16'h0010,1'b1},
        // R6 R8 clock off: pipe event lost, bus event beats clear
        '{1'b0,1'b1,1'b0,16'h0000,10'h002,1'b1,1'b0,10'h000,1'b0,1'b0,16'h0204,16'h4010,1'b0},
        // R5 R7 clock off: bus cleared, ACK clear ignored
        '{1'b0,1'b1,1'b0,16'h0000,10'h000,1'b0,1'b0,10'h000,1'b0,1'b0,16'h0204,16'h0010,1'b0},
        // R5 bus event with clock off raises irq
        '{1'b0,1'b0,1'b0,16'h0000,10'h000,1'b1,1'b0,10'h000,1'b1,1'b0,16'h0204,16'h4010,1'b1},
        // R8 pipe 2 event beats clear-all
        '{1'b1,1'b1,1'b1,16'h0000,10'h004,1'b0,1'b0,10'h004,1'b0,1'b0,16'h0004,16'h4010,1'b1},
        // R3 all-ones write changes nothing, upper bits read 0
        '{1'b1,1'b1,1'b1,16'hFFFF,10'h000,1'b0,1'b0,10'h000,1'b0,1'b0,16'h0004,16'h4010,1'b0},
        // R2 clear global view
        '{1'b1,1'b1,1'b0,16'h0000,10'h000,1'b0,1'b0,10'h000,1'b0,1'b0,16'h0004,16'h0000,1'b0},
        // R1 all pipes
        '{1'b1,1'b0,1'b0,16'h0000,10'h3FF,1'b0,1'b0,10'h3FF,1'b0,1'b0,16'h03FF,16'h0000,1'b1},
        // R2 alternating clear
        '{1'b1,1'b1,1'b1,16'h0155,10'h000,1'b0,1'b0,10'h3FF,1'b0,1'b0,16'h0155,16'h0000,1'b1},
        // R2 R9 clear all, irq drops
        '{1'b1,1'b1,1'b1,16'h0000,10'h000,1'b0,1'b0,10'h3FF,1'b0,1'b0,16'h0000,16'h0000,1'b0},
        // R6 ACK with clock off lost
        '{1'b0,1'b0,1'b0,16'h0000,10'h000,1'b0,1'b1,10'h000,1'b0,1'b1,16'h0000,16'h0000,1'b0},
        // R6 clock back on, lost event stays lost
        '{1'b1,1'b0,1'b0,16'h0000,10'h000,1'b0,1'b0,10'h000,1'b0,1'b1,16'h0000,16'h0000,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_supply_on = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic [9:0]  pipe_rdy_evt = '0;
    logic        setup_ack_evt = 1'b0;
    logic        bus_chg_evt = 1'b0;
    logic [9:0]  pipe_en = '0;
    logic        setup_ack_en = 1'b0;
    logic        bus_chg_en = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wzc_irq_status dut_i (
        .clk(clk), .rst(rst), .clk_supply_on(clk_supply_on),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .pipe_rdy_evt(pipe_rdy_evt), .setup_ack_evt(setup_ack_evt),
        .bus_chg_evt(bus_chg_evt), .pipe_en(pipe_en),
        .setup_ack_en(setup_ack_en), .bus_chg_en(bus_chg_en),
        .irq_out(irq_out)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_views(input string req, input logic [15:0] xp, input logic [15:0] xg);
        rd_sel = 1'b1; #1;
        check16({req, " pipe"}, rd_data, xp);
        rd_sel = 1'b0; #1;
        check16({req, " global"}, rd_data, xg);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check_views("R10 reset", 16'h0000, 16'h0000);
        check16("R10 reset irq", {15'b0, irq_out}, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            clk_supply_on = VECS[v].clk_on;
            wr_en         = VECS[v].we;
            wr_sel        = VECS[v].sel;
            wr_data       = VECS[v].wd;
            pipe_rdy_evt  = VECS[v].pevt;
            bus_chg_evt   = VECS[v].bus;
            setup_ack_evt = VECS[v].ack;
            pipe_en       = VECS[v].pen;
            bus_chg_en    = VECS[v].busen;
            setup_ack_en  = VECS[v].acken;
            @(negedge clk);
            wr_en = 1'b0; pipe_rdy_evt = '0; bus_chg_evt = 1'b0; setup_ack_evt = 1'b0;
            check_views($sformatf("vec %0d", v), VECS[v].xp, VECS[v].xg);
            @(negedge clk);
            check16($sformatf("R9 vec %0d irq", v), {15'b0, irq_out}, {15'b0, VECS[v].xirq});
        end

        // R10 reset mid-run clears everything
        @(negedge clk);
        clk_supply_on = 1'b1; pipe_en = 10'h3FF; bus_chg_en = 1'b1;
        pipe_rdy_evt = 10'h3FF; bus_chg_evt = 1'b1;
        @(negedge clk);
        pipe_rdy_evt = '0; bus_chg_evt = 1'b0;
        @(negedge clk);
        check16("R9 irq before reset", {15'b0, irq_out}, 16'h0001);
        rst = 1'b1;
        @(negedge clk);
        check_views("R10 mid reset", 16'h0000, 16'h0000);
        check16("R10 mid reset irq", {15'b0, irq_out}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check16("R10 irq after reset", {15'b0, irq_out}, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule